// File: doc/BRIEF.md
# Time-Slotted Shared Bus Scheduler

This block owns a single shared data bus that several nodes use both to send and to receive. Bus time is cut into a fixed number of slots. A free-running slot counter steps through them and wraps back to slot 0 after the last one. Every slot is tied ahead of time to one sender and one receiver. That binding lives in a small schedule table that software or a boot sequence loads through a write port. The block needs no request or grant handshake. In each slot it enables the scheduled sender's driver, enables the scheduled receiver's capture, and steers that sender's word onto the bus.

Table writes go to a staging copy. The running schedule takes that copy only when the counter wraps, so no period ever mixes old entries with new ones. A slot whose entry is marked unused leaves the bus idle. A sender/receiver pair may hold any number of slots in a period, which gives a heavy flow a larger share of the bus.

Top module: `tsb_bus_sched`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it falls, `node_drive`, `node_capture` and `bus_q` are all zero and `slot_q` is 0. The schedule table resets to all entries unused.
- R2: `slot_q` names the slot whose result the other outputs currently show. It goes up by one each cycle and wraps from SLOTS-1 to 0.
- R3: In a slot whose active entry is used, `node_drive` is one-hot, with bit `src` set. Node index i maps to bit i.
- R4: In a slot whose active entry is used, `node_capture` is one-hot, with bit `dst` set.
- R5: `bus_q` carries `node_wdata[src*DATA_W +: DATA_W]` as sampled in the slot's counting cycle. It is zero when the slot is unused.
- R6: A slot whose active entry has the used flag (`cfg_valid`) low gives all-zero `node_drive` and `node_capture`.
- R7: A write of `cfg_slot`/`cfg_src`/`cfg_dst`/`cfg_valid`, taken on a clock edge with `cfg_we` high, affects no output until the first wrap of the slot counter after that edge. It then applies to every later period.
- R8: One pair can occupy several slots, and it is then granted the bus in each of them every period.
- R9: `node_drive` and `node_capture` each have at most one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_slot | input | SLOT_W | Slot index being written |
| cfg_src | input | NODE_W | Sender node for that slot |
| cfg_dst | input | NODE_W | Receiver node for that slot |
| cfg_valid | input | 1 | 1 = slot used, 0 = slot idle |
| node_wdata | input | NODES*DATA_W | Concatenated per-node outgoing words, node i at bits i*DATA_W |
| node_drive | output | NODES | Per-node bus drive enable |
| node_capture | output | NODES | Per-node capture enable |
| bus_q | output | DATA_W | Shared bus word |
| slot_q | output | SLOT_W | Slot shown on the outputs |

## Verification
Every registered output shows the counter's slot one clock after that slot is counted. So the expected value for a cycle is formed from the inputs driven on the falling edge before a rising edge, pushed into a queue, and popped shortly after that rising edge. A table write reaches the outputs only in the first slot counted after the next wrap, which is at least one and at most SLOTS cycles after the write edge, plus the output register. The bench reference therefore keeps its own staging and active copies and swaps them at its own wrap. Checks inside a slot with a pending, not yet applied, change are tagged against the deferral rule.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int TSB_DEF_SLOTS  = 8;
  localparam int TSB_DEF_NODES  = 4;
  localparam int TSB_DEF_DATA_W = 16;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_XFER = 2'd1
  } slot_kind_e;
endpackage

// File: rtl/tsb_slot_counter.sv
module tsb_slot_counter #(
  parameter int SLOTS = tsb_pkg::TSB_DEF_SLOTS,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign slot = cnt_q;
  assign wrap = (cnt_q == LAST);

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (slot == '0)); // R2
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (slot == $past(slot) + 1'b1)); // R2
endmodule

// File: rtl/tsb_sched_table.sv
module tsb_sched_table #(
  parameter int SLOTS = tsb_pkg::TSB_DEF_SLOTS,
  parameter int NODES = tsb_pkg::TSB_DEF_NODES,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [NODE_W-1:0] wr_src,
  input  logic [NODE_W-1:0] wr_dst,
  input  logic              wr_valid,
  input  logic              commit,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [NODE_W-1:0] rd_src,
  output logic [NODE_W-1:0] rd_dst,
  output logic              rd_valid
);
  logic [SLOTS-1:0][NODE_W-1:0] stg_src, act_src;
  logic [SLOTS-1:0][NODE_W-1:0] stg_dst, act_dst;
  logic [SLOTS-1:0]             stg_vld, act_vld;

  logic wr_hit;
  assign wr_hit = wr_en && (int'(wr_slot) < SLOTS);

  // staging copy: written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_src <= '0;
      stg_dst <= '0;
      stg_vld <= '0;
    end else if (wr_hit) begin
      stg_src[wr_slot] <= wr_src;
      stg_dst[wr_slot] <= wr_dst;
      stg_vld[wr_slot] <= wr_valid;
    end
  end

  // active copy: replaced as a whole at the period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      act_src <= '0;
      act_dst <= '0;
      act_vld <= '0;
    end else if (commit) begin
      act_src <= stg_src;
      act_dst <= stg_dst;
      act_vld <= stg_vld;
    end
  end

  assign rd_src   = act_src[rd_slot];
  assign rd_dst   = act_dst[rd_slot];
  assign rd_valid = act_vld[rd_slot];

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_src) && $stable(act_dst) && $stable(act_vld))); // R7
  AST_TABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    commit |=> (act_vld == $past(stg_vld))); // R7
endmodule

// File: rtl/tsb_bus_steer.sv
module tsb_bus_steer #(
  parameter int NODES  = tsb_pkg::TSB_DEF_NODES,
  parameter int DATA_W = tsb_pkg::TSB_DEF_DATA_W,
  parameter int SLOT_W = 3,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SLOT_W-1:0]       slot_in,
  input  logic [NODE_W-1:0]       ent_src,
  input  logic [NODE_W-1:0]       ent_dst,
  input  logic                    ent_valid,
  input  logic [NODES*DATA_W-1:0] wdata,
  output logic [NODES-1:0]        drive,
  output logic [NODES-1:0]        capture,
  output logic [DATA_W-1:0]       bus,
  output logic [SLOT_W-1:0]       slot_out
);
  tsb_pkg::slot_kind_e kind;
  logic [NODES-1:0]  drv_n, cap_n;
  logic [DATA_W-1:0] bus_n;

  assign kind = (ent_valid && int'(ent_src) < NODES && int'(ent_dst) < NODES)
                ? tsb_pkg::SLOT_XFER : tsb_pkg::SLOT_IDLE;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    assign drv_n[i] = (kind == tsb_pkg::SLOT_XFER) && (ent_src == NODE_W'(i));
    assign cap_n[i] = (kind == tsb_pkg::SLOT_XFER) && (ent_dst == NODE_W'(i));
  end

  always_comb begin
    bus_n = '0;
    for (int i = 0; i < NODES; i++)
      if (drv_n[i]) bus_n = bus_n | wdata[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive    <= '0;
      capture  <= '0;
      bus      <= '0;
      slot_out <= '0;
    end else begin
      drive    <= drv_n;
      capture  <= cap_n;
      bus      <= bus_n;
      slot_out <= slot_in;
    end
  end

  AST_DRV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drive)); // R9
  AST_CAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(capture)); // R9
  AST_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $countones(drive) == $countones(capture)); // R4
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    (drive == '0) |-> (bus == '0)); // R6
  AST_SLOT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slot_out == $past(slot_in))); // R2
endmodule

// File: rtl/tsb_bus_sched.sv
module tsb_bus_sched #(
  parameter int SLOTS  = tsb_pkg::TSB_DEF_SLOTS,
  parameter int NODES  = tsb_pkg::TSB_DEF_NODES,
  parameter int DATA_W = tsb_pkg::TSB_DEF_DATA_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [SLOT_W-1:0]       cfg_slot,
  input  logic [NODE_W-1:0]       cfg_src,
  input  logic [NODE_W-1:0]       cfg_dst,
  input  logic                    cfg_valid,
  input  logic [NODES*DATA_W-1:0] node_wdata,
  output logic [NODES-1:0]        node_drive,
  output logic [NODES-1:0]        node_capture,
  output logic [DATA_W-1:0]       bus_q,
  output logic [SLOT_W-1:0]       slot_q
);
  logic [SLOT_W-1:0] cur_slot;
  logic              wrap;
  logic [NODE_W-1:0] e_src, e_dst;
  logic              e_vld;

  tsb_slot_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk(clk), .rst(rst), .slot(cur_slot), .wrap(wrap)
  );

  tsb_sched_table #(.SLOTS(SLOTS), .NODES(NODES)) u_tab (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_slot(cfg_slot), .wr_src(cfg_src),
    .wr_dst(cfg_dst), .wr_valid(cfg_valid),
    .commit(wrap), .rd_slot(cur_slot),
    .rd_src(e_src), .rd_dst(e_dst), .rd_valid(e_vld)
  );

  tsb_bus_steer #(.NODES(NODES), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_steer (
    .clk(clk), .rst(rst), .slot_in(cur_slot),
    .ent_src(e_src), .ent_dst(e_dst), .ent_valid(e_vld),
    .wdata(node_wdata),
    .drive(node_drive), .capture(node_capture),
    .bus(bus_q), .slot_out(slot_q)
  );
endmodule

// File: tb/sim_tsb_bus_sched.sv
module sim_tsb_bus_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int ND = 4;
  localparam int DW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  wslot = '0;
  logic [1:0]  wsrc = '0, wdst = '0;
  logic        wvld = 1'b0;
  logic [ND*DW-1:0] wdata = '0;
  logic [ND-1:0] drv, cap;
  logic [DW-1:0] bus;
  logic [2:0]    slot;

  int n_chk = 0, n_fail = 0;
  int ab_exp = 0, ab_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsb_bus_sched #(.SLOTS(N), .NODES(ND), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(we), .cfg_slot(wslot), .cfg_src(wsrc),
    .cfg_dst(wdst), .cfg_valid(wvld), .node_wdata(wdata),
    .node_drive(drv), .node_capture(cap), .bus_q(bus), .slot_q(slot)
  );

  typedef struct {
    logic [ND-1:0] drv;
    logic [ND-1:0] cap;
    logic [DW-1:0] bus;
    logic [2:0]    slot;
    logic          idle;
    logic          pend;
  } exp_t;

  exp_t q[$];

  // reference state
  int   m_slot = 0;
  logic [1:0] s_src[N], s_dst[N], a_src[N], a_dst[N];
  logic       s_v[N], a_v[N];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic e, input int sl, input int sr, input int ds, input logic v);
    exp_t x;
    we = e; wslot = 3'(sl); wsrc = 2'(sr); wdst = 2'(ds); wvld = v;
    for (int i = 0; i < ND; i++) wdata[i*DW +: DW] = 16'($urandom);
    x.slot = 3'(m_slot);
    x.idle = !a_v[m_slot];
    x.pend = (s_v[m_slot] !== a_v[m_slot]) || (s_src[m_slot] !== a_src[m_slot])
             || (s_dst[m_slot] !== a_dst[m_slot]);
    if (a_v[m_slot]) begin
      x.drv = 4'(1 << a_src[m_slot]);
      x.cap = 4'(1 << a_dst[m_slot]);
      x.bus = wdata[a_src[m_slot]*DW +: DW];
      if (a_src[m_slot] == 2'd0 && a_dst[m_slot] == 2'd1) ab_exp++;
    end else begin
      x.drv = '0; x.cap = '0; x.bus = '0;
    end
    q.push_back(x);
    if (m_slot == N-1)
      for (int i = 0; i < N; i++) begin
        a_src[i] = s_src[i]; a_dst[i] = s_dst[i]; a_v[i] = s_v[i];
      end
    if (e) begin s_src[sl] = 2'(sr); s_dst[sl] = 2'(ds); s_v[sl] = v; end
    m_slot = (m_slot + 1) % N;
    @(negedge clk);
  endtask

  task automatic idle_run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b0);
  endtask

  // monitor: pops the item due on this rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk("R2 slot", 32'(slot), 32'(x.slot));
      chk(x.idle ? "R6 drive" : (x.pend ? "R3/R7 drive" : "R3 drive"), 32'(drv), 32'(x.drv));
      chk(x.idle ? "R6 capture" : (x.pend ? "R4/R7 capture" : "R4 capture"), 32'(cap), 32'(x.cap));
      chk("R5 bus", 32'(bus), 32'(x.bus));
      chk("R9 drive onehot0", 32'($countones(drv) <= 1), 32'd1);
      if (drv == 4'b0001 && cap == 4'b0010) ab_act++;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      s_src[i] = '0; s_dst[i] = '0; s_v[i] = 1'b0;
      a_src[i] = '0; a_dst[i] = '0; a_v[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R1 drive", 32'(drv), 0);
    chk("R1 capture", 32'(cap), 0);
    chk("R1 bus", 32'(bus), 0);
    chk("R1 slot", 32'(slot), 0);
    rst = 1'b0;
    idle_run(8);                        // R6: empty table, bus idle
    // program a period; nodes A..D = 0..3; A->B twice (R8), slot 6 unused
    step(1'b1, 0, 0, 1, 1'b1);
    step(1'b1, 1, 2, 3, 1'b1);
    step(1'b1, 2, 0, 2, 1'b1);
    step(1'b1, 3, 0, 1, 1'b1);
    step(1'b1, 4, 2, 1, 1'b1);
    step(1'b1, 5, 3, 0, 1'b1);
    step(1'b1, 6, 3, 1, 1'b0);
    step(1'b1, 7, 0, 3, 1'b1);
    idle_run(24);
    // mid-period rewrite of slot 5 while counter is early in the period (R7)
    while (m_slot != 1) idle_run(1);
    step(1'b1, 5, 1, 2, 1'b1);
    idle_run(16);
    // write during the last slot: applies only after the following wrap (R7)
    while (m_slot != N-1) idle_run(1);
    step(1'b1, 0, 3, 3, 1'b0);
    idle_run(20);
    repeat (2) @(negedge clk);
    chk("R8 pair A->B grant count", 32'(ab_act), 32'(ab_exp));
    chk("R8 pair A->B used", 32'(ab_exp > 3), 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule